// File: doc/BRIEF.md
# Debounced Output-Enable Clock Stopper

This block gates a group of differential clock output pairs. Each pair has a true leg and a complement leg, and both are derived from one free-running reference clock. Active-low enable inputs decide when a pair may run. Four dedicated inputs each own one pair. Two shared inputs each reach a set of pairs chosen by a mask register. Every enable input is asynchronous. It passes through a two-flop synchronizer and a filter, so a new level counts only after it has been seen on two consecutive rising reference edges.

When an accepted enable goes high, every pair it covers finishes its current pulse and parks with both legs low. When the enable returns low, all pairs that it released start again on the same reference edge. No pulse is ever shortened or stretched.

Gating is flop based. The true-leg enable is registered on the falling reference edge, which is when the true leg is low. The complement-leg enable follows it on the next rising edge, which is when the complement leg is low.

Top module: `cs_oe_stopper`

## Requirements
- R1: An enable input held low lets its pairs run. An enable input held high stops every pair it covers.
- R2: Each enable input is synchronized by two flops. A new level is accepted only once the synchronized value has been equal on two consecutive rising edges. A level that is present at only one rising edge is ignored. A level held across two rising edges stops the covered pair for exactly two reference cycles.
- R3: Dedicated enable input k controls one pair: k=0 controls pair 0, k=1 pair 1, k=2 pair 3 and k=3 pair 6.
- R4: Shared input A covers pair i when bit i of mask A is 1, and shared input B does the same through mask B. Both masks are written on a rising edge while `mask_we` is 1.
- R5: A pair that is covered by no dedicated input and has both mask bits at 0 keeps running, whatever the enable inputs do.
- R6: On a stop, the true leg finishes its high phase and stays low. The complement leg finishes its following high phase and stays low. While parked, both legs are low.
- R7: After an enable input is driven low, the true leg of each released pair first rises on the 5th rising edge after that change (inside the 2 to 6 period window). All pairs released together resume on the same edge.
- R8: Every high pulse on any output leg lasts exactly half a reference period.
- R9: Reset clears both masks and leaves every pair running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_ded_n | input | N_DED | Dedicated active-low enables |
| oe_a_n | input | 1 | Shared active-low enable A |
| oe_b_n | input | 1 | Shared active-low enable B |
| mask_we | input | 1 | Mask write strobe |
| mask_a_wdata | input | N_PAIRS | New value for mask A |
| mask_b_wdata | input | N_PAIRS | New value for mask B |
| clk_t | output | N_PAIRS | Gated true legs |
| clk_c | output | N_PAIRS | Gated complement legs |

## Verification
Two things can land on the same reference edge:
- a stop requested by one enable group and a restart released by another group;
- a mask write and an accepted change of a shared enable.

The random phase provokes both. It writes new masks and then drives new levels on several enable inputs at once. Each pair's parked or running state is then judged against a bench model built from the dedicated map and the masks. A directed phase stops pairs from all six sources and releases them together, then checks that every true leg first rises on the same edge.

// File: rtl/cs_pkg.sv
package cs_pkg;
    // Per-input filter state: two synchronizer stages, a history bit, the accepted level
    typedef struct packed {
        logic [1:0] sync;
        logic       hold;
        logic       level;
    } flt_t;
endpackage

// File: rtl/cs_oe_filter.sv
module cs_oe_filter
    import cs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic sync_o,
    output logic level
);
    flt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], raw};
        st_d.hold = st_q.sync[1];
        // accept only a value seen on two consecutive edges after synchronization
        if (st_q.sync[1] == st_q.hold) begin
            st_d.level = st_q.sync[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.sync[1];
    assign level  = st_q.level;
endmodule

// File: rtl/cs_pair_gate.sv
module cs_pair_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    output logic en_t_o,
    output logic en_c_o,
    output logic clk_t,
    output logic clk_c
);
    logic en_t_d, en_t_q;
    logic en_c_d, en_c_q;

    always_comb begin
        en_t_d = !stop_req;
        en_c_d = en_t_q;
    end

    // true leg is low while the reference is low: update there
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_t_q <= 1'b1;
        end else begin
            en_t_q <= en_t_d;
        end
    end

    // complement leg is low while the reference is high: update there
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_c_q <= 1'b1;
        end else begin
            en_c_q <= en_c_d;
        end
    end

    assign clk_t  = clk & en_t_q;
    assign clk_c  = ~clk & en_c_q;
    assign en_t_o = en_t_q;
    assign en_c_o = en_c_q;
endmodule

// File: rtl/cs_oe_stopper.sv
module cs_oe_stopper #(
    parameter int N_PAIRS = 8,
    parameter int N_DED   = 4,
    parameter logic [N_DED-1:0][7:0] DED_PAIR = {8'd6, 8'd3, 8'd1, 8'd0}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_DED-1:0]   oe_ded_n,
    input  logic               oe_a_n,
    input  logic               oe_b_n,
    input  logic               mask_we,
    input  logic [N_PAIRS-1:0] mask_a_wdata,
    input  logic [N_PAIRS-1:0] mask_b_wdata,
    output logic [N_PAIRS-1:0] clk_t,
    output logic [N_PAIRS-1:0] clk_c
);
    localparam int N_SRC = N_DED + 2;
    localparam int IDX_A = N_DED;
    localparam int IDX_B = N_DED + 1;

    typedef struct packed {
        logic [N_PAIRS-1:0] mask_a;
        logic [N_PAIRS-1:0] mask_b;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [N_SRC-1:0]   raw_n;
    logic [N_SRC-1:0]   sync_mon;
    logic [N_SRC-1:0]   lvl;
    logic [N_PAIRS-1:0] ded_cov;
    logic [N_PAIRS-1:0] ded_hit;
    logic [N_PAIRS-1:0] stoppable;
    logic [N_PAIRS-1:0] stop_req;
    logic [N_PAIRS-1:0] en_t;
    logic [N_PAIRS-1:0] en_c;

    assign raw_n = {oe_b_n, oe_a_n, oe_ded_n};

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_flt
            cs_oe_filter u_flt (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw    (raw_n[g]),
                .sync_o (sync_mon[g]),
                .level  (lvl[g])
            );
        end
    endgenerate

    always_comb begin
        cfg_d = cfg_q;
        if (mask_we) begin
            cfg_d.mask_a = mask_a_wdata;
            cfg_d.mask_b = mask_b_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        ded_cov = '0;
        ded_hit = '0;
        for (int p = 0; p < N_PAIRS; p++) begin
            for (int k = 0; k < N_DED; k++) begin
                if (DED_PAIR[k] == 8'(p)) begin
                    ded_cov[p] = 1'b1;
                    ded_hit[p] = ded_hit[p] | lvl[k];
                end
            end
        end
    end

    assign stoppable = ded_cov | cfg_q.mask_a | cfg_q.mask_b;
    assign stop_req  = ded_hit
                     | (cfg_q.mask_a & {N_PAIRS{lvl[IDX_A]}})
                     | (cfg_q.mask_b & {N_PAIRS{lvl[IDX_B]}});

    generate
        for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
            cs_pair_gate u_gate (
                .clk      (clk),
                .rst_n    (rst_n),
                .stop_req (stop_req[i]),
                .en_t_o   (en_t[i]),
                .en_c_o   (en_c[i]),
                .clk_t    (clk_t[i]),
                .clk_c    (clk_c[i])
            );
        end
    endgenerate
endmodule

// File: rtl/cs_oe_stopper_chk.sv
module cs_oe_stopper_chk #(
    parameter int N_PAIRS = 8,
    parameter int N_SRC   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_SRC-1:0]   sync_mon,
    input logic [N_SRC-1:0]   lvl,
    input logic [N_PAIRS-1:0] stoppable,
    input logic [N_PAIRS-1:0] stop_req,
    input logic [N_PAIRS-1:0] en_t,
    input logic [N_PAIRS-1:0] en_c
);
    generate
        for (genvar j = 0; j < N_SRC; j++) begin : g_src
            // R2: an accepted level was seen on the two prior synchronized samples
            assert_debounce_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(lvl[j]) != lvl[j]) |->
                    ($past(sync_mon[j], 1) == lvl[j] && $past(sync_mon[j], 2) == lvl[j]));
        end
        for (genvar i = 0; i < N_PAIRS; i++) begin : g_pr
            // R5: a pair nobody may stop keeps its true-leg enable
            assert_free_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !stoppable[i] |-> en_t[i]);
            // R6: complement enable trails the true enable by one half period
            assert_comp_trails_R6: assert property (@(posedge clk) disable iff (!rst_n)
                en_c[i] == $past(en_t[i]));
            // R7: a pair resumes only once its stop request is gone
            assert_restart_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(en_t[i]) |-> !stop_req[i]);
        end
    endgenerate
endmodule

bind cs_oe_stopper cs_oe_stopper_chk #(
    .N_PAIRS (N_PAIRS),
    .N_SRC   (N_SRC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_mon  (sync_mon),
    .lvl       (lvl),
    .stoppable (stoppable),
    .stop_req  (stop_req),
    .en_t      (en_t),
    .en_c      (en_c)
);

// File: tb/cs_oe_stopper_tb.sv
module cs_oe_stopper_tb;
    localparam int N  = 8;
    localparam int ND = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic [ND-1:0] oe_ded_n;
    logic          oe_a_n, oe_b_n, mask_we;
    logic [N-1:0]  mwa, mwb, clk_t, clk_c;
    logic [N-1:0]  m_a, m_b;

    int checks = 0;
    int failures = 0;
    int bad_pulse = 0;
    int pulses = 0;
    bit done = 1'b0;
    int run_t[N];
    int run_c[N];

    cs_oe_stopper u_dut (
        .clk(clk), .rst_n(rst_n), .oe_ded_n(oe_ded_n), .oe_a_n(oe_a_n),
        .oe_b_n(oe_b_n), .mask_we(mask_we), .mask_a_wdata(mwa),
        .mask_b_wdata(mwb), .clk_t(clk_t), .clk_c(clk_c)
    );

    function automatic int owner(int p);
        case (p)
            0: return 0;
            1: return 1;
            3: return 2;
            6: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [N-1:0] exp_stop();
        logic [N-1:0] s;
        for (int p = 0; p < N; p++) begin
            s[p] = (m_a[p] & oe_a_n) | (m_b[p] & oe_b_n);
            if (owner(p) >= 0) s[p] = s[p] | oe_ded_n[owner(p)];
        end
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic write_masks(input logic [N-1:0] a, input logic [N-1:0] b);
        mwa = a; mwb = b; mask_we = 1'b1;
        tick(1);
        mask_we = 1'b0;
        m_a = a; m_b = b;
    endtask

    // called at posedge+2 (reference high); returns at the next posedge+2
    task automatic steady(input string req);
        logic [N-1:0] run_exp;
        run_exp = ~exp_stop();
        chk(clk_t == run_exp, req, int'(clk_t), int'(run_exp));
        chk(clk_c == '0, "R6", int'(clk_c), 0);
        @(negedge clk); #2;
        chk(clk_c == run_exp, req, int'(clk_c), int'(run_exp));
        chk(clk_t == '0, "R6", int'(clk_t), 0);
        @(posedge clk); #2;
    endtask

    // R8 pulse monitor: one sample per half period
    always @(clk) begin
        #1;
        for (int i = 0; i < N; i++) begin
            if (clk_t[i]) run_t[i]++;
            else if (run_t[i] > 0) begin
                pulses++;
                if (run_t[i] != 1) bad_pulse++;
                run_t[i] = 0;
            end
            if (clk_c[i]) run_c[i]++;
            else if (run_c[i] > 0) begin
                pulses++;
                if (run_c[i] != 1) bad_pulse++;
                run_c[i] = 0;
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cnt;
        int first[N];
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin run_t[i] = 0; run_c[i] = 0; end
        rst_n = 1'b0; oe_ded_n = '0; oe_a_n = 1'b0; oe_b_n = 1'b0;
        mask_we = 1'b0; mwa = '0; mwb = '0; m_a = '0; m_b = '0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        steady("R9");

        // R5/R9: masks are clear after reset, so shared inputs reach nothing
        oe_a_n = 1'b1; oe_b_n = 1'b1;
        tick(10);
        steady("R5");
        oe_a_n = 1'b0; oe_b_n = 1'b0;

        // R3/R1: dedicated inputs 0 and 2 stop pairs 0 and 3
        oe_ded_n = 4'b0101;
        tick(10);
        steady("R3");
        oe_ded_n = 4'b0000;
        tick(10);
        steady("R1");

        // R2: present on one rising edge only -> ignored
        oe_ded_n[1] = 1'b1;
        tick(1);
        oe_ded_n[1] = 1'b0;
        cnt = 0;
        for (int c = 0; c < 10; c++) begin
            @(posedge clk); #1;
            if (!clk_t[1]) cnt++;
        end
        chk(cnt == 0, "R2", cnt, 0);
        tick(4);

        // R2: present on two rising edges -> accepted, two stopped cycles
        oe_ded_n[1] = 1'b1;
        tick(2);
        oe_ded_n[1] = 1'b0;
        cnt = 0;
        for (int c = 0; c < 10; c++) begin
            @(posedge clk); #1;
            if (!clk_t[1]) cnt++;
        end
        chk(cnt == 2, "R2", cnt, 2);
        tick(4);

        // R4/R7: stop every pair through all six inputs, then release at once
        write_masks(8'b0011_0100, 8'b1000_0000);
        oe_ded_n = 4'hF; oe_a_n = 1'b1; oe_b_n = 1'b1;
        tick(10);
        steady("R4");
        oe_ded_n = 4'h0; oe_a_n = 1'b0; oe_b_n = 1'b0;
        for (int p = 0; p < N; p++) first[p] = -1;
        for (int c = 1; c <= 8; c++) begin
            @(posedge clk); #1;
            for (int p = 0; p < N; p++)
                if (first[p] < 0 && clk_t[p]) first[p] = c;
        end
        #1;
        for (int p = 0; p < N; p++) chk(first[p] == 5, "R7", first[p], 5);
        tick(2);
        steady("R7");

        // R4: random masks and enable levels
        for (int it = 0; it < 40; it++) begin
            if ($urandom_range(0, 1) == 1)
                write_masks(N'($urandom), N'($urandom));
            oe_ded_n = ND'($urandom);
            oe_a_n   = 1'($urandom);
            oe_b_n   = 1'($urandom);
            tick(10);
            steady("R4");
        end

        chk(bad_pulse == 0, "R8", bad_pulse, 0);
        chk(pulses > 0, "R8", pulses, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule